// File: doc/BRIEF.md
# Serial Start-Byte Slave Interface

This block is the serial front end of a display controller's register file. A host selects it by pulling chip select low and then clocks in bytes, most significant bit first. The first byte of every transaction is a start byte: a six-bit identification code, a register-select flag and a direction flag. Five bits of the code are fixed and one comes from a strap input, so two controllers can share one bus. A non-matching code makes the block stay passive until chip select is released.

On a matched write, the bytes that follow are paired into 16-bit words. Each complete word is handed to the register side with a one-cycle strobe and the register-select flag, which tells an index write from an instruction or RAM-data write. On a matched read, the block fetches 16-bit words from the register side through a request pulse and shifts them out high byte first. RAM reads are preceded by five filler bytes.

All serial inputs are oversampled by the system clock through synchronizers. The serial clock must therefore stay at each level for at least four system clock cycles.

Top module: `sbs_slave`

## Requirements
- R1: A rising chip select ends the transaction and clears all byte state. A partial byte, or an odd first byte of a pair, pending at that moment is dropped without a strobe, and the next transaction starts cleanly.
- R2: Serial input is sampled on rising serial clock edges, most significant bit first, for the start byte and all data bytes.
- R3: Start-byte bits 1 to 5 (first transmitted first) must be 01110 and bit 6 must equal `id_strap_i`. Otherwise no write strobe, no read request and no output enable occur until chip select rises.
- R4: Start-byte bit 7 is the register-select flag and bit 8 the direction flag (0 = write, 1 = read). A write carries the register-select flag on `wr_rs_o` (0 = index, 1 = instruction/RAM data).
- R5: After a write start byte, each pair of bytes forms one word, the first byte as bits 15..8 and the second as bits 7..0. Any number of words may follow one start byte, each raising its own strobe after its second byte.
- R6: A status read (flag 0, direction 1) pulses `rd_req_o` right after the start byte. It shifts out `rd_data_i` upper byte first, and requests the next word at each further byte-pair boundary. The output changes on falling serial clock edges.
- R7: A RAM read (flag 1, direction 1) shifts out five filler bytes of value 0x00 first. It then outputs words as in R6, issuing its first request at the end of the fifth filler byte.
- R8: `sdo_oe_o` is high only while a matched read is in progress with chip select low, and `sdo_o` is 0 whenever it is low.
- R9: After reset all outputs are low.
- R10: `wr_stb_o` and `rd_req_o` each last exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data in |
| id_strap_i | input | 1 | Strap giving the last identification bit |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data line |
| wr_stb_o | output | 1 | One-cycle strobe for a received word |
| wr_rs_o | output | 1 | Register-select flag of the written word |
| wr_data_o | output | 16 | Received word |
| rd_req_o | output | 1 | One-cycle request for the next read word |
| rd_rs_o | output | 1 | Register-select flag of the read (0 status, 1 RAM) |
| rd_data_i | input | 16 | Read word, sampled the cycle after the request |

## Verification
A wrong bit counter or pair flag shows up as a word with its bytes swapped or shifted. It can also show up as a strobe one byte early or late, and this is visible at the first strobe of a transaction. A stale start-byte decode after chip select rises shows up as a strobe or an enabled output in the next, mismatched transaction. A filler count off by one shifts every read byte by eight bits. This is seen on the sixth byte of a RAM read, and the number of read requests shows it as well.

// File: rtl/sbs_pkg.sv
// Shared types of the serial start-byte slave.
package sbs_pkg;
    // Transaction phase inside one chip-select window.
    typedef enum logic [1:0] {
        PH_START  = 2'd0,
        PH_ACTIVE = 2'd1,
        PH_IGNORE = 2'd2
    } phase_e;

    // Access kind latched from the start byte.
    typedef struct packed {
        logic rs;
        logic rw;
    } access_t;
endpackage

// File: rtl/sbs_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; reset value given per bit.
module sbs_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= d;
            end
        end else begin : g_next
            // Later stages pass the value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= RST_VAL;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sbs_edge.sv
// Edge detector on already-synchronized levels.
// Produces one-cycle rise and fall pulses in the system clock domain.
module sbs_edge #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/sbs_rx_shift.sv
// Receive shifter: collects bits MSB first and flags the last bit of a byte.
// byte_o is valid in the cycle byte_done is high (includes the incoming bit).
module sbs_rx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              din,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_done,
    output logic              bit_zero
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;

    // Shift in one bit per sample and count bit position.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sh  <= '0;
            cnt <= '0;
        end else if (shift_en) begin
            sh  <= {sh[BYTE_W-2:0], din};
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign byte_o    = {sh[BYTE_W-2:0], din};
    assign byte_done = shift_en && (cnt == LAST);
    assign bit_zero  = (cnt == '0);
endmodule

// File: rtl/sbs_tx_shift.sv
// Transmit shifter: loads a byte and presents its MSB, shifting left on demand.
module sbs_tx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              shift,
    output logic              q
);
    logic [BYTE_W-1:0] sh;

    // Load a new byte or move the next bit to the front.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sh <= '0;
        else if (load)     sh <= load_val;
        else if (shift)    sh <= {sh[BYTE_W-2:0], 1'b0};
    end

    assign q = sh[BYTE_W-1];
endmodule

// File: rtl/sbs_slave.sv
// Serial start-byte slave: decodes the start byte, assembles write words,
// and serves read words with filler bytes ahead of RAM data.
// Assumes each serial clock level lasts at least four system clock cycles,
// and that the register side presents rd_data_i the cycle after rd_req_o.
module sbs_slave
    import sbs_pkg::*;
#(
    parameter int                  BYTE_W      = 8,
    parameter int                  ID_FIXED_W  = 5,
    parameter logic [ID_FIXED_W-1:0] ID_FIXED  = 5'b01110,
    parameter int                  DUMMY_BYTES = 5,
    parameter int                  SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n_i,
    input  logic                  sclk_i,
    input  logic                  sdi_i,
    input  logic                  id_strap_i,
    output logic                  sdo_o,
    output logic                  sdo_oe_o,
    output logic                  wr_stb_o,
    output logic                  wr_rs_o,
    output logic [2*BYTE_W-1:0]   wr_data_o,
    output logic                  rd_req_o,
    output logic                  rd_rs_o,
    input  logic [2*BYTE_W-1:0]   rd_data_i
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int DCNT_W = $clog2(DUMMY_BYTES + 1);
    localparam int ID_BIT = 2;

    // Synchronized serial lines: {cs_n, sclk, sdi}
    logic [2:0] sync_q;
    logic       cs_s, sclk_s, sdi_s, sel;
    logic       sclk_rise, sclk_fall;

    sbs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n_i, sclk_i, sdi_i}), .q(sync_q)
    );
    assign cs_s   = sync_q[2];
    assign sclk_s = sync_q[1];
    assign sdi_s  = sync_q[0];
    assign sel    = ~cs_s;

    sbs_edge #(.W(1), .RST_VAL(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sclk_s),
        .rise(sclk_rise), .fall(sclk_fall)
    );

    // Phase and access decode
    phase_e  phase;
    access_t acc;
    logic [BYTE_W-1:0] rx_byte;
    logic rx_done, bit_zero, rx_en, id_ok;

    assign rx_en = sel && sclk_rise && (phase != PH_IGNORE);

    sbs_rx_shift #(.BYTE_W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(~sel), .shift_en(rx_en), .din(sdi_s),
        .byte_o(rx_byte), .byte_done(rx_done), .bit_zero(bit_zero)
    );

    assign id_ok = (rx_byte[BYTE_W-1 -: ID_FIXED_W] == ID_FIXED)
                && (rx_byte[ID_BIT] == id_strap_i);

    // Track the phase of the transaction and latch the access kind.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            phase <= PH_START;
            acc   <= '0;
        end else if (rx_done && phase == PH_START) begin
            phase <= id_ok ? PH_ACTIVE : PH_IGNORE;
            if (id_ok) acc <= '{rs: rx_byte[1], rw: rx_byte[0]};
        end
    end

    // Write path
    logic [BYTE_W-1:0] hi_byte;
    logic              have_hi;
    logic              wr_go;

    assign wr_go = sel && rx_done && (phase == PH_ACTIVE) && !acc.rw;

    // Pair bytes into words and pulse the strobe on the second byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_byte   <= '0;
            have_hi   <= 1'b0;
            wr_stb_o  <= 1'b0;
            wr_rs_o   <= 1'b0;
            wr_data_o <= '0;
        end else begin
            wr_stb_o <= 1'b0;
            if (!sel) begin
                have_hi <= 1'b0;
            end else if (wr_go) begin
                if (!have_hi) begin
                    hi_byte <= rx_byte;
                    have_hi <= 1'b1;
                end else begin
                    have_hi   <= 1'b0;
                    wr_stb_o  <= 1'b1;
                    wr_rs_o   <= acc.rs;
                    wr_data_o <= {hi_byte, rx_byte};
                end
            end
        end
    end

    // Read path
    logic [DCNT_W-1:0] dummy_left;
    logic              lo_next;
    logic [WORD_W-1:0] rd_word;
    logic              start_rd, rd_bound, tx_evt, tx_load, tx_shift, tx_q;
    logic [BYTE_W-1:0] tx_val;

    assign start_rd = sel && rx_done && (phase == PH_START) && id_ok && rx_byte[0];
    assign rd_bound = sel && rx_done && (phase == PH_ACTIVE) && acc.rw;
    assign tx_evt   = sel && sclk_fall && (phase == PH_ACTIVE) && acc.rw;
    assign tx_load  = tx_evt && bit_zero;
    assign tx_shift = tx_evt && !bit_zero;

    // Sequence filler bytes, word halves and read requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dummy_left <= '0;
            lo_next    <= 1'b0;
            rd_req_o   <= 1'b0;
            rd_rs_o    <= 1'b0;
        end else begin
            rd_req_o <= 1'b0;
            if (!sel) begin
                dummy_left <= '0;
                lo_next    <= 1'b0;
            end else if (start_rd) begin
                dummy_left <= rx_byte[1] ? DCNT_W'(DUMMY_BYTES) : '0;
                lo_next    <= 1'b0;
                rd_req_o   <= !rx_byte[1];
                rd_rs_o    <= rx_byte[1];
            end else begin
                if (rd_bound)
                    rd_req_o <= (dummy_left == '0) && !lo_next;
                if (tx_load) begin
                    if (dummy_left != '0) dummy_left <= dummy_left - 1'b1;
                    else                  lo_next    <= ~lo_next;
                end
            end
        end
    end

    // Capture the word the register side returns for a request.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_word <= '0;
        else if (rd_req_o) rd_word <= rd_data_i;
    end

    // Choose the next byte to send.
    always_comb begin
        if (dummy_left != '0) tx_val = '0;
        else if (lo_next)     tx_val = rd_word[BYTE_W-1:0];
        else                  tx_val = rd_word[WORD_W-1:BYTE_W];
    end

    sbs_tx_shift #(.BYTE_W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(~sel), .load(tx_load),
        .load_val(tx_val), .shift(tx_shift), .q(tx_q)
    );

    assign sdo_oe_o = sel && (phase == PH_ACTIVE) && acc.rw;
    assign sdo_o    = sdo_oe_o & tx_q;
endmodule

// File: rtl/sbs_slave_chk.sv
// Property checker for sbs_slave, attached by bind.
module sbs_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n_i,
    input logic sdo_oe_o,
    input logic wr_stb_o,
    input logic rd_req_o
);
    // R10
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // R10
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    // R8
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !sdo_oe_o);

    // R8
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> !sdo_oe_o);

    // R6
    req_vs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> !rd_req_o);
endmodule

bind sbs_slave sbs_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i),
    .sdo_oe_o(sdo_oe_o), .wr_stb_o(wr_stb_o), .rd_req_o(rd_req_o)
);

// File: tb/sbs_slave_test.sv
// Scoreboard bench for sbs_slave.
module sbs_slave_test;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, strap = 1'b0;
    logic sdo, sdo_oe, wr_stb, wr_rs, rd_req, rd_rs;
    logic [15:0] wr_data;
    logic [15:0] rd_data = 16'h0000;

    int checks = 0, errors = 0;
    int stb_cnt = 0, req_cnt = 0;
    logic [16:0] wq [$];
    logic [15:0] rq [$];
    logic prev_stb = 1'b0;

    always #5 clk = ~clk;

    sbs_slave uut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .id_strap_i(strap), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .wr_stb_o(wr_stb),
        .wr_rs_o(wr_rs), .wr_data_o(wr_data), .rd_req_o(rd_req), .rd_rs_o(rd_rs),
        .rd_data_i(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected writes, supplies read words, counts pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_stb) begin
                stb_cnt++;
                chk(!prev_stb, "R10", "strobe width", 2, 1);
                if (wq.size() == 0)
                    chk(1'b0, "R5", "unexpected strobe", {15'd0, wr_rs, wr_data}, 0);
                else begin
                    logic [16:0] e;
                    e = wq.pop_front();
                    chk({wr_rs, wr_data} == e, "R5", "written word",
                        {wr_rs, wr_data}, e);
                end
            end
            if (rd_req) begin
                req_cnt++;
                rd_data <= (rq.size() != 0) ? rq.pop_front() : 16'h0000;
            end
        end
        prev_stb <= wr_stb;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_high();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(4 * HALF);
    endtask

    // Shift nbits of b out MSB first, capturing sdo and oe before each rise.
    task automatic xfer(input logic [7:0] b, input int nbits,
                        output logic [7:0] got, output bit oe_all);
        got = 8'h00;
        oe_all = 1'b1;
        for (int i = 7; i > 7 - nbits; i--) begin
            sdi = b[i];
            wait_clk(HALF);
            got[i] = sdo;
            oe_all = oe_all & sdo_oe;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] g;
        bit o;
        xfer(b, 8, g, o);
    endtask

    initial begin : main
        logic [7:0] g;
        bit o;
        int s0, r0;
        logic [7:0] exp_ram [9];

        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        // R9 reset state
        chk(sdo_oe == 0 && sdo == 0, "R9", "sdo after reset", {sdo_oe, sdo}, 0);
        chk(wr_stb == 0 && rd_req == 0, "R9", "pulses after reset", {wr_stb, rd_req}, 0);

        // R4 index write, R2 MSB first
        wq.push_back({1'b0, 16'h1234});
        cs_low(); send(8'h70); send(8'h12); send(8'h34); cs_high();
        chk(wq.size() == 0, "R4", "index write delivered", wq.size(), 0);

        // R5 several words in one window, instruction write
        wq.push_back({1'b1, 16'hA55A});
        wq.push_back({1'b1, 16'h0F0F});
        wq.push_back({1'b1, 16'hFFFF});
        cs_low(); send(8'h72);
        send(8'hA5); send(8'h5A); send(8'h0F); send(8'h0F); send(8'hFF); send(8'hFF);
        cs_high();
        chk(wq.size() == 0, "R5", "three words delivered", wq.size(), 0);

        // R3 strap high selects id bit 1
        strap = 1'b1;
        wq.push_back({1'b1, 16'hBEEF});
        cs_low(); send(8'h76); send(8'hBE); send(8'hEF); cs_high();
        chk(wq.size() == 0, "R3", "strap-matched write", wq.size(), 0);

        // R3 strap mismatch ignored
        s0 = stb_cnt;
        cs_low(); send(8'h72); send(8'h55); send(8'h66); cs_high();
        chk(stb_cnt == s0, "R3", "strap mismatch strobes", stb_cnt - s0, 0);
        strap = 1'b0;

        // R3 wrong fixed bits ignored, read not enabled
        s0 = stb_cnt; r0 = req_cnt;
        cs_low(); send(8'h61); xfer(8'h00, 8, g, o); xfer(8'h00, 8, g, o); cs_high();
        chk(stb_cnt == s0 && req_cnt == r0, "R3", "bad id pulses", stb_cnt - s0 + req_cnt - r0, 0);
        chk(o == 1'b0 || sdo_oe == 1'b0, "R8", "oe on bad id", o, 0);
        chk(sdo_oe == 1'b0, "R8", "oe after bad id", sdo_oe, 0);

        // R1 odd trailing byte dropped
        wq.push_back({1'b1, 16'h1122});
        s0 = stb_cnt;
        cs_low(); send(8'h72); send(8'h11); send(8'h22); send(8'h33); cs_high();
        chk(stb_cnt - s0 == 1, "R1", "odd trailing byte", stb_cnt - s0, 1);

        // R1 partial byte dropped, next transaction clean
        s0 = stb_cnt;
        cs_low(); send(8'h72); send(8'h44); xfer(8'hF0, 4, g, o); cs_high();
        chk(stb_cnt == s0, "R1", "partial byte strobes", stb_cnt - s0, 0);
        wq.push_back({1'b0, 16'h0001});
        cs_low(); send(8'h70); send(8'h00); send(8'h01); cs_high();
        chk(wq.size() == 0, "R1", "clean restart", wq.size(), 0);

        // R6 status read
        rq.push_back(16'hC3A5);
        r0 = req_cnt;
        cs_low(); send(8'h71);
        xfer(8'h00, 8, g, o);
        chk(g == 8'hC3, "R6", "status upper byte", g, 8'hC3);
        chk(o, "R8", "oe during status read", o, 1);
        xfer(8'h00, 8, g, o);
        chk(g == 8'hA5, "R6", "status lower byte", g, 8'hA5);
        chk(rd_rs == 1'b0, "R6", "status flag", rd_rs, 0);
        cs_high();
        chk(req_cnt - r0 == 2, "R6", "status requests", req_cnt - r0, 2);
        chk(sdo_oe == 1'b0, "R8", "oe after read", sdo_oe, 0);

        // R7 RAM read with filler bytes
        rq.push_back(16'h1357);
        rq.push_back(16'h9BDF);
        exp_ram = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h13, 8'h57, 8'h9B, 8'hDF};
        r0 = req_cnt;
        cs_low(); send(8'h73);
        for (int k = 0; k < 9; k++) begin
            xfer(8'h00, 8, g, o);
            chk(g == exp_ram[k], "R7", $sformatf("RAM byte %0d", k), g, exp_ram[k]);
        end
        chk(rd_rs == 1'b1, "R7", "RAM flag", rd_rs, 1);
        cs_high();
        chk(req_cnt - r0 == 3, "R7", "RAM requests", req_cnt - r0, 3);

        chk(wq.size() == 0, "R5", "scoreboard drained", wq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule